// File: doc/BRIEF.md
# Time-Aware Egress Gate Scheduler

This block drives the eight transmission gates of one egress port, one gate per traffic class. It runs a cyclic gate control list of up to sixteen entries. Each entry pairs an 8-bit gate mask with a hold time in nanoseconds. The list starts at a programmed absolute start time, measured against a free-running nanosecond time input, and repeats every cycle period.

Every decision resolves on a 200 ns slot grid. Entry hold times, the cycle period and the start time are all rounded up to whole slots when they are written. As a result, the gate vector can only change on a slot boundary.

A second schedule served by the same engine reports its gate events as slot numbers. The block raises a collision pulse whenever one of its own events falls in the same slot as a reported event. Software gets an error pulse instead of a silently misbehaving schedule.

Top module: `gate_sched_top`

## Requirements
- R1: After reset, `gate_open` is 0xFF and `cfg_err` and `collision` are low.
- R2: While `sched_en` is low, or before the current slot reaches the start slot, `gate_open` is 0xFF.
- R3: Once running, `gate_open` equals the mask of the list entry whose window contains the current slot. Bit n opens traffic class n. Entries run in index order from entry 0, and the output reflects the time input sampled two clock cycles earlier.
- R4: Hold times, the cycle period and the start time are rounded up to a multiple of 200 ns. While enabled, `gate_open` changes only together with a gate event of the schedule.
- R5: At start slot + k × period, the list returns to entry 0. An entry whose window extends past the period end is cut off there. The last entry is held until the period ends, even if the entries add up to less than the period.
- R6: Write map, selected by `cfg_addr`:
  - 0..15 writes entry n, with the mask in `cfg_wdata[7:0]` and the hold time in ns in `cfg_wdata[31:8]`.
  - 16 writes the entry count (1..16).
  - 17 writes the period in ns.
  - 18 writes the start time in ns.
  - Count, period and start time take effect only on the next rising edge of `sched_en`. Until then the running schedule continues unchanged.
- R7: The following writes raise `cfg_err` for one cycle, on the clock after the write, and leave all stored state unchanged:
  - a zero hold time;
  - a zero period;
  - a count of 0 or more than 16;
  - an address above 18.
  
  Accepted writes never raise `cfg_err`.
- R8: `collision` pulses when a peer event (`peer_evt_valid` with `peer_evt_slot`) and a gate event of this schedule fall in the same slot, in either arrival order.
- R9: A peer event in a slot where this schedule has no event produces no `collision`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_ns | input | TIME_W | Free-running time in nanoseconds |
| sched_en | input | 1 | Schedule enable; a rising edge loads count, period and start |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration address |
| cfg_wdata | input | TIME_W | Configuration write data |
| peer_evt_valid | input | 1 | A gate event of the other schedule is reported |
| peer_evt_slot | input | TIME_W | Slot number of the reported peer event |
| gate_open | output | 8 | Gate-open vector, bit n for traffic class n |
| cfg_err | output | 1 | One-cycle pulse on a rejected write |
| collision | output | 1 | One-cycle pulse on a same-slot event clash |

## Verification
The gate vector depends on the time value driven two clock cycles before it is read. The first register converts time to a slot number, and the second is the sequencer state. The bench therefore compares `gate_open` on every falling edge against its model evaluated at the time driven two cycles earlier. `cfg_err` is due on the first falling edge after the write strobe. A collision arrives one cycle after the own event, which is itself two cycles after time enters the slot. For that reason the collision checks count pulses until time is more than two slots past the probed slot, rather than sampling at a single edge.

// File: rtl/gate_sched_pkg.sv
package gate_sched_pkg;
    localparam int GATES = 8;
    typedef logic [GATES-1:0] gate_t;
    localparam gate_t ALL_OPEN = '1;
endpackage

// File: rtl/gsched_cfg.sv
module gsched_cfg
    import gate_sched_pkg::*;
#(
    parameter int TIME_W  = 48,
    parameter int DUR_W   = 24,
    parameter int MAX_ENT = 16,
    parameter int SLOT_NS = 200,
    localparam int ADDR_W = $clog2(MAX_ENT + 3),
    localparam int CNT_W  = $clog2(MAX_ENT + 1),
    localparam int IDX_W  = $clog2(MAX_ENT)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [TIME_W-1:0]                 cfg_wdata,
    output gate_t [MAX_ENT-1:0]               ent_mask,
    output logic  [MAX_ENT-1:0][DUR_W-1:0]    ent_dur,
    output logic  [CNT_W-1:0]                 sh_cnt,
    output logic  [TIME_W-1:0]                sh_cyc,
    output logic  [TIME_W-1:0]                sh_base,
    output logic                              cfg_err
);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(MAX_ENT);
    localparam logic [ADDR_W-1:0] A_CYC  = ADDR_W'(MAX_ENT + 1);
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(MAX_ENT + 2);

    typedef struct packed {
        gate_t [MAX_ENT-1:0]            mask;
        logic  [MAX_ENT-1:0][DUR_W-1:0] dur;
        logic  [CNT_W-1:0]              cnt;
        logic  [TIME_W-1:0]             cyc;
        logic  [TIME_W-1:0]             base;
        logic                           err;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic [DUR_W-1:0] dur_ns;

    // ceil(ns / SLOT_NS), computed with one extra bit of headroom
    function automatic logic [TIME_W-1:0] ns_to_slots(input logic [TIME_W-1:0] ns);
        logic [TIME_W:0] sum;
        sum = {1'b0, ns} + (TIME_W+1)'(SLOT_NS - 1);
        return TIME_W'(sum / (TIME_W+1)'(SLOT_NS));
    endfunction

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.err = 1'b0;
        dur_ns    = cfg_wdata[GATES +: DUR_W];
        if (cfg_we) begin
            if (cfg_addr < A_CNT) begin
                if (dur_ns == '0) begin
                    cfg_d.err = 1'b1;
                end else begin
                    cfg_d.mask[cfg_addr[IDX_W-1:0]] = cfg_wdata[GATES-1:0];
                    cfg_d.dur[cfg_addr[IDX_W-1:0]]  =
                        DUR_W'(ns_to_slots({{(TIME_W-DUR_W){1'b0}}, dur_ns}));
                end
            end else if (cfg_addr == A_CNT) begin
                if (cfg_wdata == '0 || cfg_wdata > TIME_W'(MAX_ENT)) begin
                    cfg_d.err = 1'b1;
                end else begin
                    cfg_d.cnt = cfg_wdata[CNT_W-1:0];
                end
            end else if (cfg_addr == A_CYC) begin
                if (cfg_wdata == '0) begin
                    cfg_d.err = 1'b1;
                end else begin
                    cfg_d.cyc = ns_to_slots(cfg_wdata);
                end
            end else if (cfg_addr == A_BASE) begin
                cfg_d.base = ns_to_slots(cfg_wdata);
            end else begin
                cfg_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask <= '1;
            cfg_q.dur  <= {MAX_ENT{DUR_W'(1)}};
            cfg_q.cnt  <= CNT_W'(1);
            cfg_q.cyc  <= TIME_W'(1);
            cfg_q.base <= '0;
            cfg_q.err  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ent_mask = cfg_q.mask;
    assign ent_dur  = cfg_q.dur;
    assign sh_cnt   = cfg_q.cnt;
    assign sh_cyc   = cfg_q.cyc;
    assign sh_base  = cfg_q.base;
    assign cfg_err  = cfg_q.err;
endmodule

// File: rtl/gsched_seq.sv
module gsched_seq
    import gate_sched_pkg::*;
#(
    parameter int TIME_W  = 48,
    parameter int DUR_W   = 24,
    parameter int MAX_ENT = 16,
    parameter int SLOT_NS = 200,
    localparam int CNT_W  = $clog2(MAX_ENT + 1),
    localparam int IDX_W  = $clog2(MAX_ENT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [TIME_W-1:0]              time_ns,
    input  logic                           sched_en,
    input  gate_t [MAX_ENT-1:0]            ent_mask,
    input  logic  [MAX_ENT-1:0][DUR_W-1:0] ent_dur,
    input  logic  [CNT_W-1:0]              sh_cnt,
    input  logic  [TIME_W-1:0]             sh_cyc,
    input  logic  [TIME_W-1:0]             sh_base,
    output gate_t                          gate_open,
    output logic                           evt,
    output logic  [TIME_W-1:0]             evt_slot
);
    typedef struct packed {
        logic [TIME_W-1:0] slot;
        logic              en;
        logic              run;
        logic [IDX_W-1:0]  idx;
        logic [TIME_W-1:0] cyc_start;
        logic [TIME_W-1:0] ent_end;
        logic [CNT_W-1:0]  cnt;
        logic [TIME_W-1:0] cyc;
        logic [TIME_W-1:0] base;
        gate_t             gate;
        logic              evt;
        logic [TIME_W-1:0] evt_slot;
    } seq_st_t;

    seq_st_t seq_d, seq_q;
    logic [TIME_W-1:0] cyc_end;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  nxt_idx;

    function automatic logic [TIME_W-1:0] widen(input logic [DUR_W-1:0] d);
        return {{(TIME_W-DUR_W){1'b0}}, d};
    endfunction

    always_comb begin
        seq_d      = seq_q;
        seq_d.evt  = 1'b0;
        seq_d.slot = time_ns / TIME_W'(SLOT_NS);
        seq_d.en   = sched_en;
        cyc_end    = seq_q.cyc_start + seq_q.cyc;
        last_idx   = IDX_W'(seq_q.cnt - CNT_W'(1));
        nxt_idx    = seq_q.idx + IDX_W'(1);
        if (!sched_en) begin
            seq_d.run  = 1'b0;
            seq_d.gate = ALL_OPEN;
        end else if (!seq_q.en) begin
            // rising enable: load the deferred parameters
            seq_d.cnt  = sh_cnt;
            seq_d.cyc  = sh_cyc;
            seq_d.base = sh_base;
            seq_d.run  = 1'b0;
            seq_d.gate = ALL_OPEN;
        end else if (!seq_q.run) begin
            if (seq_q.slot >= seq_q.base) begin
                seq_d.run       = 1'b1;
                seq_d.idx       = '0;
                seq_d.cyc_start = seq_q.base;
                seq_d.ent_end   = seq_q.base + widen(ent_dur[0]);
                seq_d.gate      = ent_mask[0];
                seq_d.evt       = 1'b1;
                seq_d.evt_slot  = seq_q.slot;
            end
        end else if (seq_q.slot >= cyc_end) begin
            seq_d.idx       = '0;
            seq_d.cyc_start = cyc_end;
            seq_d.ent_end   = cyc_end + widen(ent_dur[0]);
            seq_d.gate      = ent_mask[0];
            seq_d.evt       = 1'b1;
            seq_d.evt_slot  = seq_q.slot;
        end else if (seq_q.slot >= seq_q.ent_end && seq_q.idx != last_idx) begin
            seq_d.idx      = nxt_idx;
            seq_d.ent_end  = seq_q.ent_end + widen(ent_dur[nxt_idx]);
            seq_d.gate     = ent_mask[nxt_idx];
            seq_d.evt      = 1'b1;
            seq_d.evt_slot = seq_q.slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q           <= '0;
            seq_q.cnt       <= CNT_W'(1);
            seq_q.cyc       <= TIME_W'(1);
            seq_q.gate      <= ALL_OPEN;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign gate_open = seq_q.gate;
    assign evt       = seq_q.evt;
    assign evt_slot  = seq_q.evt_slot;
endmodule

// File: rtl/gsched_clash.sv
module gsched_clash #(
    parameter int TIME_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_evt,
    input  logic [TIME_W-1:0] own_slot,
    input  logic              peer_valid,
    input  logic [TIME_W-1:0] peer_slot,
    output logic              collision
);
    typedef struct packed {
        logic              own_seen;
        logic [TIME_W-1:0] own_last;
        logic              peer_seen;
        logic [TIME_W-1:0] peer_last;
        logic              hit;
    } clash_st_t;

    clash_st_t cl_d, cl_q;

    always_comb begin
        cl_d     = cl_q;
        cl_d.hit = (own_evt && peer_valid && own_slot == peer_slot)
                || (own_evt && cl_q.peer_seen && cl_q.peer_last == own_slot)
                || (peer_valid && cl_q.own_seen && cl_q.own_last == peer_slot);
        if (own_evt) begin
            cl_d.own_seen = 1'b1;
            cl_d.own_last = own_slot;
        end
        if (peer_valid) begin
            cl_d.peer_seen = 1'b1;
            cl_d.peer_last = peer_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cl_q <= '0;
        else        cl_q <= cl_d;
    end

    assign collision = cl_q.hit;
endmodule

// File: rtl/gate_sched_top.sv
module gate_sched_top
    import gate_sched_pkg::*;
#(
    parameter int TIME_W  = 48,
    parameter int DUR_W   = 24,
    parameter int MAX_ENT = 16,
    parameter int SLOT_NS = 200,
    localparam int ADDR_W = $clog2(MAX_ENT + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_ns,
    input  logic              sched_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [TIME_W-1:0] cfg_wdata,
    input  logic              peer_evt_valid,
    input  logic [TIME_W-1:0] peer_evt_slot,
    output logic [GATES-1:0]  gate_open,
    output logic              cfg_err,
    output logic              collision
);
    localparam int CNT_W = $clog2(MAX_ENT + 1);

    gate_t [MAX_ENT-1:0]            ent_mask;
    logic  [MAX_ENT-1:0][DUR_W-1:0] ent_dur;
    logic  [CNT_W-1:0]              sh_cnt;
    logic  [TIME_W-1:0]             sh_cyc;
    logic  [TIME_W-1:0]             sh_base;
    logic                           own_evt;
    logic  [TIME_W-1:0]             own_slot;

    gsched_cfg #(.TIME_W(TIME_W), .DUR_W(DUR_W), .MAX_ENT(MAX_ENT), .SLOT_NS(SLOT_NS)) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ent_mask(ent_mask), .ent_dur(ent_dur), .sh_cnt(sh_cnt), .sh_cyc(sh_cyc),
        .sh_base(sh_base), .cfg_err(cfg_err)
    );

    gsched_seq #(.TIME_W(TIME_W), .DUR_W(DUR_W), .MAX_ENT(MAX_ENT), .SLOT_NS(SLOT_NS)) i_seq (
        .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .sched_en(sched_en),
        .ent_mask(ent_mask), .ent_dur(ent_dur), .sh_cnt(sh_cnt), .sh_cyc(sh_cyc),
        .sh_base(sh_base), .gate_open(gate_open), .evt(own_evt), .evt_slot(own_slot)
    );

    gsched_clash #(.TIME_W(TIME_W)) i_clash (
        .clk(clk), .rst_n(rst_n), .own_evt(own_evt), .own_slot(own_slot),
        .peer_valid(peer_evt_valid), .peer_slot(peer_evt_slot), .collision(collision)
    );
endmodule

// File: rtl/gsched_chk.sv
module gsched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sched_en,
    input logic       cfg_we,
    input logic       cfg_err,
    input logic [7:0] gate_open,
    input logic       collision,
    input logic       own_evt,
    input logic       peer_evt_valid
);
    p_idle_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_en |=> gate_open == 8'hFF);

    p_gate_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(gate_open) && $past(sched_en)) |-> own_evt);

    p_err_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we));

    p_quiet_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> !cfg_err);

    p_clash_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> $past(own_evt || peer_evt_valid));
endmodule

bind gate_sched_top gsched_chk i_gsched_chk (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .cfg_we(cfg_we), .cfg_err(cfg_err),
    .gate_open(gate_open), .collision(collision), .own_evt(own_evt),
    .peer_evt_valid(peer_evt_valid)
);

// File: tb/test_gate_sched_top.sv
module test_gate_sched_top;
    localparam int CLK_PERIOD = 10;
    localparam int STEP_NS    = 40;
    localparam int TIME_W     = 48;
    localparam int MAX_ENT    = 16;
    localparam int SLOT_NS    = 200;
    localparam int ADDR_W     = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TIME_W-1:0] time_ns = '0;
    logic              sched_en = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [TIME_W-1:0] cfg_wdata = '0;
    logic              peer_evt_valid = 1'b0;
    logic [TIME_W-1:0] peer_evt_slot = '0;
    logic [7:0]        gate_open;
    logic              cfg_err;
    logic              collision;

    gate_sched_top i_gate_sched_top (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int     checks = 0, errors = 0, coll_cnt = 0;
    bit     done = 0, chk_on = 0, model_on = 0;
    string  tag = "R3";
    longint b_mask[MAX_ENT], b_dur[MAX_ENT];
    longint sh_cnt = 1, sh_cyc = 1, sh_base = 0;
    longint a_cnt = 1, a_cyc = 1, a_base = 0;
    longint t_d1 = 0;

    function automatic longint slots_of(longint ns);
        return (ns + SLOT_NS - 1) / SLOT_NS;
    endfunction

    function automatic longint exp_gate(longint t);
        longint s, off, acc;
        if (!model_on) return 'hFF;
        s = t / SLOT_NS;
        if (s < a_base) return 'hFF;
        off = (s - a_base) % a_cyc;
        acc = 0;
        for (int i = 0; i < a_cnt; i++) begin
            if (i == a_cnt - 1) return b_mask[i];
            acc += b_dur[i];
            if (off < acc) return b_mask[i];
        end
        return 'hFF;
    endfunction

    function automatic bit is_evt(longint s);
        longint off, acc;
        if (s < a_base) return 0;
        off = (s - a_base) % a_cyc;
        if (off == 0) return 1;
        acc = 0;
        for (int i = 0; i < a_cnt - 1; i++) begin
            acc += b_dur[i];
            if (acc == off) return 1;
        end
        return 0;
    endfunction

    task automatic chk(string req, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        string tg;
        @(negedge clk);
        if (collision) coll_cnt++;
        if (chk_on) begin
            tg = (model_on && t_d1 / SLOT_NS >= a_base) ? tag : "R2";
            chk(tg, gate_open, exp_gate(t_d1));
        end
        t_d1 = time_ns;
        time_ns += STEP_NS;
    endtask

    task automatic run(longint n);
        for (longint i = 0; i < n; i++) step();
    endtask

    task automatic wr(int addr, longint data, bit exp_err);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_wdata = TIME_W'(data);
        step();
        cfg_we = 1'b0;
        chk(exp_err ? "R7" : "R6", cfg_err, exp_err);
    endtask

    task automatic wr_ent(int i, longint mask, longint dur_ns);
        wr(i, (dur_ns << 8) | mask, dur_ns == 0);
        if (dur_ns != 0) begin b_mask[i] = mask; b_dur[i] = slots_of(dur_ns); end
    endtask

    task automatic wr_cnt(longint v);
        wr(16, v, v == 0 || v > MAX_ENT);
        if (v != 0 && v <= MAX_ENT) sh_cnt = v;
    endtask

    task automatic wr_cyc(longint ns);
        wr(17, ns, ns == 0);
        if (ns != 0) sh_cyc = slots_of(ns);
    endtask

    task automatic wr_base_ahead();
        longint ns;
        ns = longint'(time_ns) + 1000 + $urandom % 1000;
        wr(18, ns, 0);
        sh_base = slots_of(ns);
    endtask

    task automatic en_on();
        sched_en = 1'b1; model_on = 1; a_cnt = sh_cnt; a_cyc = sh_cyc; a_base = sh_base;
    endtask

    task automatic en_off();
        sched_en = 1'b0; model_on = 0;
        run(3);
    endtask

    // run until about 'cycles' full periods after the start slot
    task automatic run_cycles(longint cycles);
        longint n;
        n = (a_base * SLOT_NS - longint'(time_ns)) / STEP_NS + cycles * a_cyc * (SLOT_NS / STEP_NS) + 20;
        run(n);
    endtask

    task automatic clash_probe(bit want_evt);
        longint s;
        s = longint'(time_ns) / SLOT_NS + 3;
        while (is_evt(s) != want_evt) s++;
        coll_cnt = 0;
        peer_evt_valid = 1'b1; peer_evt_slot = TIME_W'(s);
        step();
        peer_evt_valid = 1'b0;
        while (longint'(time_ns) / SLOT_NS <= s + 2) step();
        if (want_evt) chk("R8", coll_cnt >= 1, 1);
        else          chk("R9", coll_cnt, 0);
    endtask

    initial begin
        longint sum;
        void'($urandom(32'd7331));
        for (int i = 0; i < MAX_ENT; i++) begin b_mask[i] = 'hFF; b_dur[i] = 1; end
        run(3);
        rst_n = 1'b1;
        step();
        chk("R1", gate_open, 'hFF);
        chk("R1", cfg_err, 0);
        chk("R1", collision, 0);
        chk_on = 1;

        // R7: rejected writes
        wr_cnt(0);
        wr_cnt(17);
        wr_cyc(0);
        wr_ent(3, 'h12, 0);
        wr(31, 5, 1);

        // R3: two-entry schedule, high class then the rest, 10 us + 40 us in 50 us
        wr_ent(0, 'h80, 10000);
        wr_ent(1, 'h7F, 40000);
        wr_cnt(2);
        wr_cyc(50000);
        wr_base_ahead();
        tag = "R3";
        en_on();
        run_cycles(2);

        // R7: zero-duration entry write while running leaves entry 0 intact
        tag = "R7";
        wr_ent(0, 'h55, 0);
        run(1300);

        // R6: new count/period wait for re-enable
        tag = "R6";
        wr_cyc(20000);
        wr_cnt(1);
        run(1300);
        en_off();
        wr_base_ahead();
        en_on();
        run_cycles(1);
        en_off();

        // R4: rounding of 250 / 1 / 601 ns to 2 / 1 / 4 slots, period 10 slots
        wr_ent(0, 'h01, 250);
        wr_ent(1, 'h02, 1);
        wr_ent(2, 'h04, 601);
        wr_cnt(3);
        wr_cyc(2000);
        wr_base_ahead();
        tag = "R4";
        en_on();
        run_cycles(2);
        clash_probe(1);
        clash_probe(0);
        clash_probe(1);
        clash_probe(0);
        en_off();

        // R5: entries exceed the period and are truncated
        for (int i = 0; i < 4; i++) wr_ent(i, longint'(1) << i, 600);
        wr_cnt(4);
        wr_cyc(1000);
        wr_base_ahead();
        tag = "R5";
        en_on();
        run_cycles(4);
        en_off();

        // R5: last entry is held until the period ends
        wr_ent(0, 'h0F, 200);
        wr_ent(1, 'hF0, 200);
        wr_cnt(2);
        wr_cyc(2000);
        wr_base_ahead();
        en_on();
        run_cycles(3);
        en_off();

        // R3: random schedules
        tag = "R3";
        for (int sc = 0; sc < 8; sc++) begin
            longint cnt;
            cnt = 1 + $urandom % MAX_ENT;
            sum = 0;
            for (int i = 0; i < cnt; i++) begin
                longint d;
                d = 1 + $urandom % 900;
                sum += d;
                wr_ent(i, $urandom % 256, d);
            end
            wr_cnt(cnt);
            wr_cyc(200 + $urandom % (sum + 2000));
            wr_base_ahead();
            en_on();
            run_cycles(2);
            clash_probe(1);
            en_off();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule